// File: doc/BRIEF.md
# Segment Translation and Protection Unit

This block turns a logical address, made of a segment number and an offset inside that segment, into a physical address. It keeps a small table of segment descriptors. Each descriptor holds a starting physical address, a length, a present bit and three access-right bits. Two control registers go with the table. The origin register says which table row serves segment 0. The count register says how many segments are in use.

Each request carries a segment number, an offset and an access kind. The unit runs four checks in a fixed order: segment number against the count, the present bit, the offset against the length, and then the access rights. The first check that fails sets a fault flag and a 3-bit code, and no address is produced. If every check passes, the physical address is the base plus the offset. The result appears one cycle after the request.

A configuration port writes descriptor rows and the two registers. A write becomes visible to requests issued in the following cycle.

Top module: `seg_xlate`

## Requirements
- R1: After reset, `out_vld`, `out_fault`, `out_code` and `out_pa` are 0. All rows are not present, and both the origin and the count registers are 0, so any request faults with code 1.
- R2: `out_vld` is high exactly one cycle after a cycle in which `in_vld` is high, and low otherwise.
- R3: A request with `in_seg` greater than or equal to the count register faults with code 1. This check has the highest priority.
- R4: A request whose segment passes R3 and whose row has the present bit at 0 faults with code 2.
- R5: A request that passes R3 and R4 and whose offset is greater than or equal to the row's length faults with code 3.
- R6: A request that passes R3 to R5 faults with code 4 when its access is not allowed. The access kinds are: `in_acc` 0 read, which needs rights bit 0; 1 write, which needs bit 1; 2 execute, which needs bit 2; and 3, which is always refused.
- R7: A request that passes every check gives `out_fault` 0, `out_code` 0 and `out_pa` equal to (base + offset) mod 2^24.
- R8: When `out_fault` is 1, `out_code` is nonzero and `out_pa` is 0. On a valid result, `out_fault` is 1 exactly when `out_code` is nonzero.
- R9: The table row used for a request is (origin + `in_seg`) mod 16.
- R10: A configuration write takes effect for requests in the next cycle. A request in the same cycle as the write sees the old contents.
- R11: `cfg_sel` selects what a write updates:
  - 0 writes row `cfg_idx` (base, length, rights, present bit).
  - 1 loads the origin register from `cfg_idx`.
  - 2 loads the count register from `cfg_len`.
  - 3 changes nothing.
- R12: In a cycle where `out_vld` is 0, `out_fault`, `out_code` and `out_pa` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_vld | input | 1 | Request strobe |
| in_seg | input | 4 | Segment number |
| in_off | input | 16 | Offset inside the segment |
| in_acc | input | 2 | Access kind: 0 read, 1 write, 2 execute, 3 refused |
| out_vld | output | 1 | Result strobe, one cycle after the request |
| out_fault | output | 1 | Request refused |
| out_code | output | 3 | 0 ok, 1 segment out of range, 2 not present, 3 beyond length, 4 rights |
| out_pa | output | 24 | Physical address, 0 on fault |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Write target: 0 row, 1 origin, 2 count, 3 none |
| cfg_idx | input | 4 | Row index, or the origin value |
| cfg_base | input | 24 | Row base address |
| cfg_limit | input | 17 | Row length in bytes, 0 to 65536 |
| cfg_perm | input | 3 | Rights: bit 0 read, bit 1 write, bit 2 execute |
| cfg_valid | input | 1 | Row present bit |
| cfg_len | input | 5 | Count value, 0 to 16 |

## Verification
The bench builds the unit with its default widths: a 4-bit segment number, a 16-bit offset and a 24-bit address. With these widths the count register can reach 16, so every segment number can be made legal. A length of 65536 lets every offset pass the length check. Bases near the top of the address space make the modulo wrap of the sum reachable. The origin register is stepped through several values, so the row rotation of R9 is covered across the whole table.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;
  typedef enum logic [2:0] {
    FLT_NONE    = 3'd0,
    FLT_SEG     = 3'd1,
    FLT_ABSENT  = 3'd2,
    FLT_LENGTH  = 3'd3,
    FLT_RIGHTS  = 3'd4
  } fault_e;

  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_EXEC  = 2'd2,
    ACC_RSVD  = 2'd3
  } acc_e;

  typedef enum logic [1:0] {
    CFG_ROW    = 2'd0,
    CFG_ORIGIN = 2'd1,
    CFG_COUNT  = 2'd2,
    CFG_IDLE   = 2'd3
  } cfg_e;

  function automatic logic rights_ok(input logic [1:0] acc, input logic [2:0] perm);
    case (acc)
      ACC_READ:  rights_ok = perm[0];
      ACC_WRITE: rights_ok = perm[1];
      ACC_EXEC:  rights_ok = perm[2];
      default:   rights_ok = 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/seg_table.sv
module seg_table #(
  parameter int SEG_W = 4,
  parameter int OFF_W = 16,
  parameter int PA_W  = 24,
  localparam int DEPTH = 1 << SEG_W,
  localparam int LIM_W = OFF_W + 1,
  localparam int CNT_W = SEG_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [1:0]       cfg_sel,
  input  logic [SEG_W-1:0] cfg_idx,
  input  logic [PA_W-1:0]  cfg_base,
  input  logic [LIM_W-1:0] cfg_limit,
  input  logic [2:0]       cfg_perm,
  input  logic             cfg_valid,
  input  logic [CNT_W-1:0] cfg_len,
  input  logic [SEG_W-1:0] rd_seg,
  output logic [PA_W-1:0]  rd_base,
  output logic [LIM_W-1:0] rd_limit,
  output logic [2:0]       rd_perm,
  output logic             rd_present,
  output logic [CNT_W-1:0] seg_count
);
  import seg_xlate_pkg::*;

  function automatic logic [SEG_W-1:0] row_of(input logic [SEG_W-1:0] origin,
                                              input logic [SEG_W-1:0] seg);
    row_of = origin + seg;
  endfunction

  logic [PA_W-1:0]  base_q  [DEPTH];
  logic [LIM_W-1:0] limit_q [DEPTH];
  logic [2:0]       perm_q  [DEPTH];
  logic [DEPTH-1:0] present_q;
  logic [SEG_W-1:0] origin_q;
  logic [CNT_W-1:0] count_q;
  logic [SEG_W-1:0] row;

  for (genvar i = 0; i < DEPTH; i++) begin : g_row
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        base_q[i]    <= '0;
        limit_q[i]   <= '0;
        perm_q[i]    <= '0;
        present_q[i] <= 1'b0;
      end else if (cfg_we && cfg_sel == CFG_ROW && cfg_idx == SEG_W'(i)) begin
        base_q[i]    <= cfg_base;
        limit_q[i]   <= cfg_limit;
        perm_q[i]    <= cfg_perm;
        present_q[i] <= cfg_valid;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      origin_q <= '0;
      count_q  <= '0;
    end else if (cfg_we) begin
      if (cfg_sel == CFG_ORIGIN) origin_q <= cfg_idx;
      if (cfg_sel == CFG_COUNT)  count_q  <= cfg_len;
    end
  end

  assign row        = row_of(origin_q, rd_seg);
  assign rd_base    = base_q[row];
  assign rd_limit   = limit_q[row];
  assign rd_perm    = perm_q[row];
  assign rd_present = present_q[row];
  assign seg_count  = count_q;
endmodule

// File: rtl/seg_check.sv
module seg_check #(
  parameter int SEG_W = 4,
  parameter int OFF_W = 16,
  parameter int PA_W  = 24,
  localparam int LIM_W = OFF_W + 1,
  localparam int CNT_W = SEG_W + 1
) (
  input  logic [SEG_W-1:0] seg,
  input  logic [OFF_W-1:0] off,
  input  logic [1:0]       acc,
  input  logic [CNT_W-1:0] seg_count,
  input  logic [PA_W-1:0]  base,
  input  logic [LIM_W-1:0] limit,
  input  logic [2:0]       perm,
  input  logic             present,
  output logic             seg_ok,
  output logic             present_ok,
  output logic             length_ok,
  output logic             rights_pass,
  output logic [2:0]       code,
  output logic [PA_W-1:0]  pa
);
  import seg_xlate_pkg::*;

  function automatic logic [PA_W-1:0] phys_of(input logic [PA_W-1:0] b,
                                              input logic [OFF_W-1:0] o);
    phys_of = b + PA_W'(o);
  endfunction

  assign seg_ok      = CNT_W'(seg) < seg_count;
  assign present_ok  = present;
  assign length_ok   = LIM_W'(off) < limit;
  assign rights_pass = rights_ok(acc, perm);

  always_comb begin
    pa = '0;
    if (!seg_ok)           code = FLT_SEG;
    else if (!present_ok)  code = FLT_ABSENT;
    else if (!length_ok)   code = FLT_LENGTH;
    else if (!rights_pass) code = FLT_RIGHTS;
    else begin
      code = FLT_NONE;
      pa   = phys_of(base, off);
    end
  end
endmodule

// File: rtl/seg_xlate.sv
module seg_xlate #(
  parameter int SEG_W = 4,
  parameter int OFF_W = 16,
  parameter int PA_W  = 24,
  localparam int LIM_W = OFF_W + 1,
  localparam int CNT_W = SEG_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_vld,
  input  logic [SEG_W-1:0] in_seg,
  input  logic [OFF_W-1:0] in_off,
  input  logic [1:0]       in_acc,
  output logic             out_vld,
  output logic             out_fault,
  output logic [2:0]       out_code,
  output logic [PA_W-1:0]  out_pa,
  input  logic             cfg_we,
  input  logic [1:0]       cfg_sel,
  input  logic [SEG_W-1:0] cfg_idx,
  input  logic [PA_W-1:0]  cfg_base,
  input  logic [LIM_W-1:0] cfg_limit,
  input  logic [2:0]       cfg_perm,
  input  logic             cfg_valid,
  input  logic [CNT_W-1:0] cfg_len
);
  logic [PA_W-1:0]  ent_base;
  logic [LIM_W-1:0] ent_limit;
  logic [2:0]       ent_perm;
  logic             ent_present;
  logic [CNT_W-1:0] seg_count;
  logic             ev_seg_ok, ev_present_ok, ev_length_ok, ev_rights_ok;
  logic [2:0]       chk_code;
  logic [PA_W-1:0]  chk_pa;

  seg_table #(.SEG_W(SEG_W), .OFF_W(OFF_W), .PA_W(PA_W)) u_table (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_idx(cfg_idx), .cfg_base(cfg_base),
    .cfg_limit(cfg_limit), .cfg_perm(cfg_perm), .cfg_valid(cfg_valid), .cfg_len(cfg_len),
    .rd_seg(in_seg), .rd_base(ent_base), .rd_limit(ent_limit), .rd_perm(ent_perm),
    .rd_present(ent_present), .seg_count(seg_count)
  );

  seg_check #(.SEG_W(SEG_W), .OFF_W(OFF_W), .PA_W(PA_W)) u_check (
    .seg(in_seg), .off(in_off), .acc(in_acc), .seg_count(seg_count),
    .base(ent_base), .limit(ent_limit), .perm(ent_perm), .present(ent_present),
    .seg_ok(ev_seg_ok), .present_ok(ev_present_ok), .length_ok(ev_length_ok),
    .rights_pass(ev_rights_ok), .code(chk_code), .pa(chk_pa)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_vld   <= 1'b0;
      out_fault <= 1'b0;
      out_code  <= '0;
      out_pa    <= '0;
    end else begin
      out_vld   <= in_vld;
      out_fault <= in_vld && (chk_code != 3'd0);
      out_code  <= in_vld ? chk_code : 3'd0;
      out_pa    <= in_vld ? chk_pa : '0;
    end
  end
endmodule

// File: rtl/seg_xlate_chk.sv
module seg_xlate_chk #(
  parameter int PA_W = 24
) (
  input logic            clk,
  input logic            rst_n,
  input logic            in_vld,
  input logic            out_vld,
  input logic            out_fault,
  input logic [2:0]      out_code,
  input logic [PA_W-1:0] out_pa,
  input logic            ev_seg_ok,
  input logic            ev_present_ok,
  input logic            ev_length_ok,
  input logic            ev_rights_ok
);
  assert_result_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_vld |=> out_vld);

  assert_idle_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !in_vld |=> (!out_vld && !out_fault && out_code == 3'd0 && out_pa == '0));

  assert_seg_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && !ev_seg_ok) |=> (out_fault && out_code == 3'd1));

  assert_absent_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && ev_seg_ok && !ev_present_ok) |=> (out_code == 3'd2));

  assert_length_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && ev_seg_ok && ev_present_ok && !ev_length_ok) |=> (out_code == 3'd3));

  assert_rights_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && ev_seg_ok && ev_present_ok && ev_length_ok && !ev_rights_ok)
      |=> (out_code == 3'd4));

  assert_pass_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && ev_seg_ok && ev_present_ok && ev_length_ok && ev_rights_ok)
      |=> (out_vld && !out_fault));

  assert_fault_shape_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_fault |-> (out_vld && out_code != 3'd0 && out_pa == '0));
endmodule

bind seg_xlate seg_xlate_chk #(.PA_W(PA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .out_vld(out_vld),
  .out_fault(out_fault), .out_code(out_code), .out_pa(out_pa),
  .ev_seg_ok(ev_seg_ok), .ev_present_ok(ev_present_ok),
  .ev_length_ok(ev_length_ok), .ev_rights_ok(ev_rights_ok)
);

// File: tb/seg_xlate_tb.sv
module seg_xlate_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_vld = 1'b0;
  logic [3:0]  in_seg = '0;
  logic [15:0] in_off = '0;
  logic [1:0]  in_acc = '0;
  logic        out_vld, out_fault;
  logic [2:0]  out_code;
  logic [23:0] out_pa;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_sel = '0;
  logic [3:0]  cfg_idx = '0;
  logic [23:0] cfg_base = '0;
  logic [16:0] cfg_limit = '0;
  logic [2:0]  cfg_perm = '0;
  logic        cfg_valid = 1'b0;
  logic [4:0]  cfg_len = '0;

  int total = 0;
  int bad = 0;
  bit done = 0;
  string phase = "reset";

  always #(CLK_PERIOD/2) clk = ~clk;

  seg_xlate u_dut (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_seg(in_seg), .in_off(in_off),
    .in_acc(in_acc), .out_vld(out_vld), .out_fault(out_fault), .out_code(out_code),
    .out_pa(out_pa), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_idx(cfg_idx),
    .cfg_base(cfg_base), .cfg_limit(cfg_limit), .cfg_perm(cfg_perm),
    .cfg_valid(cfg_valid), .cfg_len(cfg_len)
  );

  // Behavioural reference model
  int  m_base [16];
  int  m_lim  [16];
  int  m_perm [16];
  bit  m_pres [16];
  int  m_origin, m_count;
  bit  e_vld, e_fault;
  int  e_code, e_pa;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 16; i++) begin
        m_base[i] = 0; m_lim[i] = 0; m_perm[i] = 0; m_pres[i] = 0;
      end
      m_origin = 0; m_count = 0;
      e_vld = 0; e_fault = 0; e_code = 0; e_pa = 0;
    end else begin
      e_vld = in_vld; e_code = 0; e_pa = 0;
      if (in_vld) begin
        int r;
        r = (m_origin + int'(in_seg)) % 16;
        if (int'(in_seg) >= m_count) e_code = 1;
        else if (!m_pres[r]) e_code = 2;
        else if (int'(in_off) >= m_lim[r]) e_code = 3;
        else if (in_acc == 2'd3 || ((m_perm[r] >> in_acc) & 1) == 0) e_code = 4;
        else e_pa = (m_base[r] + int'(in_off)) % (1 << 24);
      end
      e_fault = (e_code != 0);
      if (cfg_we) begin
        case (cfg_sel)
          2'd0: begin
            m_base[cfg_idx] = int'(cfg_base); m_lim[cfg_idx] = int'(cfg_limit);
            m_perm[cfg_idx] = int'(cfg_perm); m_pres[cfg_idx] = cfg_valid;
          end
          2'd1: m_origin = int'(cfg_idx);
          2'd2: m_count = int'(cfg_len);
          default: ;
        endcase
      end
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      string tag;
      total++;
      if (!rst_n) tag = "R1";
      else if (!e_vld) tag = "R12";
      else if (e_code == 0) tag = "R7";
      else tag = $sformatf("R%0d", e_code + 2);
      if (out_vld !== e_vld) begin
        bad++;
        $display("FAIL R2 [%s] out_vld=%0b expected %0b", phase, out_vld, e_vld);
      end else if (out_fault !== e_fault || int'(out_code) != e_code || int'(out_pa) != e_pa) begin
        bad++;
        $display("FAIL %s (R8) [%s] fault=%0b code=%0d pa=%06h expected fault=%0b code=%0d pa=%06h",
                 tag, phase, out_fault, out_code, out_pa, e_fault, e_code, e_pa);
      end
    end
  end

  task automatic idle();
    @(negedge clk);
    in_vld = 0; cfg_we = 0;
  endtask

  task automatic wr_row(input int idx, input int base, input int lim, input int perm, input bit pres);
    @(negedge clk);
    in_vld = 0; cfg_we = 1; cfg_sel = 2'd0; cfg_idx = 4'(idx);
    cfg_base = 24'(base); cfg_limit = 17'(lim); cfg_perm = 3'(perm); cfg_valid = pres;
  endtask

  task automatic wr_reg(input int sel, input int val);
    @(negedge clk);
    in_vld = 0; cfg_we = 1; cfg_sel = 2'(sel); cfg_idx = 4'(val); cfg_len = 5'(val);
  endtask

  task automatic req(input int seg, input int off, input int acc);
    @(negedge clk);
    cfg_we = 0; in_vld = 1; in_seg = 4'(seg); in_off = 16'(off); in_acc = 2'(acc);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1; total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int lcg;
    lcg = 32'h1234_5678;
    repeat (3) @(negedge clk);
    phase = "R1 after reset";
    rst_n = 1;
    req(0, 0, 0);            // R1/R3: count is 0 after reset
    req(15, 5, 2);
    idle();

    phase = "R11 setup";
    wr_reg(2, 8);            // count = 8
    wr_row(0, 24'h001000, 17'h100, 3'b001, 1);
    wr_row(1, 24'h020000, 17'h10000, 3'b111, 1);
    wr_row(2, 24'h030000, 17'h0, 3'b111, 1);   // zero length
    wr_row(3, 24'hFFFF00, 17'h1000, 3'b010, 1); // wraps
    wr_row(4, 24'h040000, 17'h800, 3'b100, 0);  // not present
    wr_row(5, 24'h050000, 17'h400, 3'b101, 1);
    idle();

    phase = "R3-R7 directed";
    req(0, 16'h0FF, 0);      // R7 last byte
    req(0, 16'h100, 0);      // R5 at length
    req(0, 16'h010, 1);      // R6 write denied
    req(1, 16'hFFFF, 2);     // R7 full range
    req(1, 16'h0, 3);        // R6 reserved kind
    req(2, 16'h0, 0);        // R5 zero length
    req(3, 16'h0200, 1);     // R7 wrap
    req(4, 16'h900, 3);      // R4 beats length and rights
    req(8, 16'h0, 0);        // R3 at count
    req(12, 16'hFFFF, 3);    // R3 priority over all
    idle();

    phase = "R11 ignored select";
    @(negedge clk);
    cfg_we = 1; cfg_sel = 2'd3; cfg_idx = 4'd7; cfg_len = 5'd1; cfg_base = 24'hABCDEF;
    req(1, 16'h20, 0);       // still count 8, origin 0
    idle();

    phase = "R10 same-cycle write";
    @(negedge clk);
    in_vld = 1; in_seg = 4'd5; in_off = 16'h10; in_acc = 2'd0;
    cfg_we = 1; cfg_sel = 2'd0; cfg_idx = 4'd5; cfg_base = 24'h0A0000;
    cfg_limit = 17'h20; cfg_perm = 3'b001; cfg_valid = 1;
    req(5, 16'h10, 0);       // sees new row 5
    req(5, 16'h20, 0);
    idle();

    phase = "R9 origin rotation";
    wr_reg(2, 16);
    for (int i = 6; i < 16; i++) wr_row(i, 24'h100000 + i * 24'h1000, 17'h200 + i, i % 8, (i % 5) != 0);
    for (int o = 0; o < 16; o += 3) begin
      wr_reg(1, o);
      for (int s = 0; s < 16; s++) req(s, 16'h1F0 + s, s % 4);
    end
    idle();

    phase = "R2 mixed traffic";
    for (int k = 0; k < 400; k++) begin
      lcg = lcg * 1103515245 + 12345;
      if (((lcg >>> 8) & 15) == 0) wr_reg(1, (lcg >>> 12) & 15);
      else if (((lcg >>> 8) & 15) == 1) wr_reg(2, (lcg >>> 12) % 17);
      else if (((lcg >>> 8) & 15) == 2)
        wr_row((lcg >>> 12) & 15, lcg & 24'hFFFFFF, (lcg >>> 4) & 17'h1FFFF, (lcg >>> 20) & 7, (lcg >>> 24) & 1);
      else if (((lcg >>> 8) & 15) < 5) idle();
      else req((lcg >>> 12) & 15, (lcg >>> 14) & 16'hFFFF, (lcg >>> 28) & 3);
    end
    idle();
    idle();

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule